// File: doc/BRIEF.md
# Transmit Status Statistics Accumulator

This block sits beside an Ethernet transmit MAC and digests the one-byte status word the MAC reports after each frame attempt. Every accepted status byte is decoded into a collision weight and an output-error weight, which are added to two running counters. The counters saturate at all ones rather than wrapping, and a synchronous clear input zeroes both. The block also keeps a carrier-present flag, a transmit-busy flag and a one-cycle reset request that is raised when the MAC reports a transmit underflow.

Status bytes arrive on a valid/ready stream. The block never applies back-pressure once out of reset: `st_ready` is low only during reset and in the first cycle after reset is released, and is high from then on. A byte transfers on any rising edge where both `st_valid` and `st_ready` are high; a byte offered while `st_ready` is low is not taken and has no effect. All results are registered and appear one clock after the transfer edge. Control pins (`tx_launch`, `carrier_seen`, `clear_counts`) are plain single-cycle level inputs sampled on each rising edge.

Top module: `txs_stats_accum`

## Requirements
- R1: While reset is held, `st_ready` is low; from the second rising edge after reset release onward `st_ready` stays high, and a status byte transfers on each edge where `st_valid` and `st_ready` are both high.
- R2: A transferred status byte with bit 7 (status valid) clear changes no output other than what the control pins cause on their own.
- R3: A transferred byte with bit 7 and bit 6 (underflow) set raises `reset_req` for the following cycle and leaves both counters, `carrier_ok` and `tx_busy` unchanged; `reset_req` is low in every cycle not following such a transfer.
- R4: For a valid, non-underflow byte, bit 5 (late collision) adds 1 to the collision count and 1 to the error count.
- R5: For a valid, non-underflow byte, retry class is decoded by priority: bit 4 (several retries) adds 2 collisions; else bit 3 (one retry) adds 1 collision; else bit 0 (retry failure) adds 16 collisions and 1 error. These add to any R4 and R6 contributions.
- R6: For a valid, non-underflow byte, bit 1 (carrier lost) clears `carrier_ok` and adds 1 error. A `carrier_seen` pulse sets `carrier_ok`; if both happen on the same edge, the loss wins.
- R7: Bit 2 (deferred) has no effect on any output.
- R8: `tx_launch` sets `tx_busy`; a valid, non-underflow byte clears it; if both occur on the same edge, `tx_busy` is set.
- R9: Each counter saturates at all ones: when an addition would exceed the maximum the counter holds the maximum.
- R10: `clear_counts` zeroes both counters on the next edge and takes priority over a status transferred on the same edge.
- R11: After reset both counters are zero, `carrier_ok` is high, `tx_busy` and `reset_req` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| st_valid | input | 1 | Status byte offered |
| st_ready | output | 1 | Block can take a status byte |
| st_data | input | 8 | Transmit status byte |
| tx_launch | input | 1 | A frame has been handed to the MAC |
| carrier_seen | input | 1 | Carrier observed on the medium |
| clear_counts | input | 1 | Synchronous clear of both counters |
| coll_count | output | CNT_W | Saturating collision count |
| err_count | output | CNT_W | Saturating output-error count |
| carrier_ok | output | 1 | Carrier believed present |
| tx_busy | output | 1 | A frame is awaiting its status |
| reset_req | output | 1 | One-cycle request to reset the MAC after underflow |

## Verification
Every result of this block is due exactly one rising edge after the stimulus that causes it: counter increments, the clear, the carrier and busy flags and the reset request all settle in the registers clocked at the transfer edge. The bench drives each stimulus on a falling edge, lets one rising edge pass, and compares all outputs shortly after that edge against a model advanced by the same single step, so no result is ever sampled early or late. The readiness ramp after reset is checked the same way, edge by edge.

// File: rtl/txs_pkg.sv
package txs_pkg;
  localparam int STB_VALID = 7;
  localparam int STB_UFLO  = 6;
  localparam int STB_LATE  = 5;
  localparam int STB_MANY  = 4;
  localparam int STB_ONCE  = 3;
  localparam int STB_DEFER = 2;
  localparam int STB_NOCAR = 1;
  localparam int STB_RFAIL = 0;

  localparam int COLL_INC_W = 5;
  localparam int ERR_INC_W  = 2;

  typedef struct packed {
    logic                  settle;
    logic                  fatal;
    logic                  lose_car;
    logic [COLL_INC_W-1:0] coll_inc;
    logic [ERR_INC_W-1:0]  err_inc;
  } upd_t;
endpackage

// File: rtl/txs_decode.sv
module txs_decode
  import txs_pkg::*;
(
  input  logic       take,
  input  logic [7:0] status,
  output upd_t       upd
);
  logic good;
  logic [COLL_INC_W-1:0] retry_w;
  logic                  retry_e;

  always_comb begin
    good = take && status[STB_VALID];
    retry_e = 1'b0;
    if (status[STB_MANY])       retry_w = COLL_INC_W'(2);
    else if (status[STB_ONCE])  retry_w = COLL_INC_W'(1);
    else if (status[STB_RFAIL]) begin
      retry_w = COLL_INC_W'(16);
      retry_e = 1'b1;
    end else                    retry_w = '0;

    upd = '0;
    upd.fatal = good && status[STB_UFLO];
    if (good && !status[STB_UFLO]) begin
      upd.settle   = 1'b1;
      upd.lose_car = status[STB_NOCAR];
      upd.coll_inc = retry_w + COLL_INC_W'(status[STB_LATE]);
      upd.err_inc  = ERR_INC_W'(status[STB_LATE]) + ERR_INC_W'(retry_e)
                   + ERR_INC_W'(status[STB_NOCAR]);
    end
  end
endmodule

// File: rtl/txs_sat_counter.sv
module txs_sat_counter #(
  parameter int W     = 32,
  parameter int INC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [INC_W-1:0] inc,
  output logic [W-1:0]     cnt
);
  localparam logic [W-1:0] TOP = '1;
  logic [W:0] sum;

  always_comb sum = {1'b0, cnt} + (W+1)'(inc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (clr)     cnt <= '0;
    else if (sum[W])  cnt <= TOP;
    else              cnt <= sum[W-1:0];
  end
endmodule

// File: rtl/txs_stats_accum.sv
module txs_stats_accum
  import txs_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             st_valid,
  output logic             st_ready,
  input  logic [7:0]       st_data,
  input  logic             tx_launch,
  input  logic             carrier_seen,
  input  logic             clear_counts,
  output logic [CNT_W-1:0] coll_count,
  output logic [CNT_W-1:0] err_count,
  output logic             carrier_ok,
  output logic             tx_busy,
  output logic             reset_req
);
  upd_t upd;
  logic take;

  assign take = st_valid && st_ready;

  txs_decode u_dec (
    .take   (take),
    .status (st_data),
    .upd    (upd)
  );

  txs_sat_counter #(.W(CNT_W), .INC_W(COLL_INC_W)) u_coll (
    .clk (clk), .rst_n (rst_n), .clr (clear_counts),
    .inc (upd.coll_inc), .cnt (coll_count)
  );

  txs_sat_counter #(.W(CNT_W), .INC_W(ERR_INC_W)) u_err (
    .clk (clk), .rst_n (rst_n), .clr (clear_counts),
    .inc (upd.err_inc), .cnt (err_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_ready   <= 1'b0;
      carrier_ok <= 1'b1;
      tx_busy    <= 1'b0;
      reset_req  <= 1'b0;
    end else begin
      st_ready  <= 1'b1;
      reset_req <= upd.fatal;
      if (upd.lose_car)      carrier_ok <= 1'b0;
      else if (carrier_seen) carrier_ok <= 1'b1;
      if (tx_launch)         tx_busy <= 1'b1;
      else if (upd.settle)   tx_busy <= 1'b0;
    end
  end
endmodule

// File: rtl/txs_stats_accum_chk.sv
module txs_stats_accum_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             st_valid,
  input logic             st_ready,
  input logic [7:0]       st_data,
  input logic             tx_launch,
  input logic             clear_counts,
  input logic [CNT_W-1:0] coll_count,
  input logic [CNT_W-1:0] err_count,
  input logic             carrier_ok,
  input logic             tx_busy,
  input logic             reset_req
);
  logic xfer;
  assign xfer = st_valid && st_ready;

  a_r2_invalid_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    xfer && !st_data[7] && !clear_counts |=> $stable(coll_count) && $stable(err_count));

  a_r3_uflo_request: assert property (@(posedge clk) disable iff (!rst_n)
    xfer && st_data[7] && st_data[6] |=> reset_req);

  a_r3_uflo_no_count: assert property (@(posedge clk) disable iff (!rst_n)
    xfer && st_data[7] && st_data[6] && !clear_counts && !tx_launch
    |=> $stable(coll_count) && $stable(err_count) && $stable(tx_busy));

  a_r3_req_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !(xfer && st_data[7] && st_data[6]) |=> !reset_req);

  a_r6_carrier_loss: assert property (@(posedge clk) disable iff (!rst_n)
    xfer && st_data[7] && !st_data[6] && st_data[1] |=> !carrier_ok);

  a_r8_launch_busy: assert property (@(posedge clk) disable iff (!rst_n)
    tx_launch |=> tx_busy);

  a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (&coll_count) && !clear_counts |=> (&coll_count));

  a_r9_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_counts |=> (coll_count >= $past(coll_count)) && (err_count >= $past(err_count)));

  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clear_counts |=> (coll_count == '0) && (err_count == '0));
endmodule

bind txs_stats_accum txs_stats_accum_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .st_valid     (st_valid),
  .st_ready     (st_ready),
  .st_data      (st_data),
  .tx_launch    (tx_launch),
  .clear_counts (clear_counts),
  .coll_count   (coll_count),
  .err_count    (err_count),
  .carrier_ok   (carrier_ok),
  .tx_busy      (tx_busy),
  .reset_req    (reset_req)
);

// File: tb/txs_stats_accum_test.sv
`timescale 1ns/1ps
module txs_stats_accum_test;
  localparam int CW = 8;
  localparam longint MAXV = (64'd1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic st_valid = 1'b0;
  logic st_ready;
  logic [7:0] st_data = '0;
  logic tx_launch = 1'b0;
  logic carrier_seen = 1'b0;
  logic clear_counts = 1'b0;
  logic [CW-1:0] coll_count, err_count;
  logic carrier_ok, tx_busy, reset_req;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  longint m_coll, m_err;
  bit m_car, m_busy, m_req, m_rdy;

  always #5 clk = ~clk;

  txs_stats_accum #(.CNT_W(CW)) uut (
    .clk (clk), .rst_n (rst_n), .st_valid (st_valid), .st_ready (st_ready),
    .st_data (st_data), .tx_launch (tx_launch), .carrier_seen (carrier_seen),
    .clear_counts (clear_counts), .coll_count (coll_count), .err_count (err_count),
    .carrier_ok (carrier_ok), .tx_busy (tx_busy), .reset_req (reset_req)
  );

  function automatic longint coll_weight(input logic [7:0] s);
    longint w = 0;
    if (s[5]) w += 1;
    case (1'b1)
      s[4]:    w += 2;
      s[3]:    w += 1;
      s[0]:    w += 16;
      default: w += 0;
    endcase
    return w;
  endfunction

  function automatic longint err_weight(input logic [7:0] s);
    longint w = 0;
    if (s[5]) w += 1;
    if (!s[4] && !s[3] && s[0]) w += 1;
    if (s[1]) w += 1;
    return w;
  endfunction

  function automatic longint sat_add(input longint a, input longint b);
    return (a + b > MAXV) ? MAXV : a + b;
  endfunction

  task automatic compare(input string tag);
    checks++;
    if (st_ready !== m_rdy) begin
      errors++; $display("FAIL %s R1 st_ready act=%0b exp=%0b", tag, st_ready, m_rdy);
    end
    if (coll_count !== CW'(m_coll)) begin
      errors++; $display("FAIL %s coll_count act=%0d exp=%0d", tag, coll_count, m_coll);
    end
    if (err_count !== CW'(m_err)) begin
      errors++; $display("FAIL %s err_count act=%0d exp=%0d", tag, err_count, m_err);
    end
    if (carrier_ok !== m_car) begin
      errors++; $display("FAIL %s R6 carrier_ok act=%0b exp=%0b", tag, carrier_ok, m_car);
    end
    if (tx_busy !== m_busy) begin
      errors++; $display("FAIL %s R8 tx_busy act=%0b exp=%0b", tag, tx_busy, m_busy);
    end
    if (reset_req !== m_req) begin
      errors++; $display("FAIL %s R3 reset_req act=%0b exp=%0b", tag, reset_req, m_req);
    end
  endtask

  // Called on a falling edge: drive, advance model, pass one rising edge, compare.
  task automatic step(input string tag, input bit v, input logic [7:0] d,
                      input bit launch, input bit cseen, input bit clr);
    bit take, good, fat;
    st_valid = v; st_data = d; tx_launch = launch;
    carrier_seen = cseen; clear_counts = clr;
    take = v && m_rdy;
    good = take && d[7] && !d[6];
    fat  = take && d[7] && d[6];
    m_req = fat;
    if (clr) begin
      m_coll = 0; m_err = 0;
    end else if (good) begin
      m_coll = sat_add(m_coll, coll_weight(d));
      m_err  = sat_add(m_err, err_weight(d));
    end
    if (good && d[1]) m_car = 0;
    else if (cseen)   m_car = 1;
    if (launch)       m_busy = 1;
    else if (good)    m_busy = 0;
    m_rdy = 1;
    @(posedge clk); #2;
    compare(tag);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_coll = 0; m_err = 0; m_car = 1; m_busy = 0; m_req = 0; m_rdy = 0;
    repeat (3) @(negedge clk);
    compare("R11 reset state");
    rst_n = 1'b1;
    // first edge after release: ready not yet up, offered byte is dropped (R1)
    step("R1 dropped before ready", 1, 8'hA0, 0, 0, 0);
    step("R1 ready up", 0, 8'h00, 0, 0, 0);

    step("R8 launch", 0, 8'h00, 1, 0, 0);
    step("R2 invalid byte ignored", 1, 8'h7F, 0, 0, 0);
    step("R4 late collision", 1, 8'hA0, 0, 0, 0);
    step("R5 many retries", 1, 8'h98, 0, 0, 0);
    step("R5 one retry", 1, 8'h88, 0, 0, 0);
    step("R5 retry failure", 1, 8'h81, 0, 0, 0);
    step("R5 priority many over fail", 1, 8'h91, 0, 0, 0);
    step("R7 deferred only", 1, 8'h84, 0, 0, 0);
    step("R8 launch again", 0, 8'h00, 1, 0, 0);
    step("R3 underflow", 1, 8'hFF, 0, 0, 0);
    step("R3 pulse ends", 0, 8'h00, 0, 0, 0);
    step("R6 carrier lost", 1, 8'h82, 0, 0, 0);
    step("R6 loss beats seen", 1, 8'h82, 0, 1, 0);
    step("R6 carrier seen", 0, 8'h00, 0, 1, 0);
    step("R8 launch beats settle", 1, 8'h80, 1, 0, 0);
    step("R10 clear beats status", 1, 8'hA1, 0, 0, 1);
    for (int i = 0; i < 20; i++) step("R9 saturate", 1, 8'hA3, 0, 0, 0);
    step("R10 clear after saturation", 0, 8'h00, 0, 0, 1);

    for (int i = 0; i < 400; i++) begin
      logic [7:0] d = 8'($urandom);
      bit v  = ($urandom % 4) != 0;
      bit l  = ($urandom % 5) == 0;
      bit cs = ($urandom % 6) == 0;
      bit cl = ($urandom % 40) == 0;
      if (($urandom % 3) != 0) d[6] = 1'b0;
      step("random R2 R4 R5 R6 R9", v, d, l, cs, cl);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule